// File: doc/BRIEF.md
# Four-Context Configuration Memory Row Controller

This block sits next to one multi-context configuration memory and decides, every clock, which context row is read, which is written and which is refreshed. Three agents share the row lines. An operating-context switch loads a new configuration into the logic. Programming reads and writes go through the dedicated programming lines. A background refresh keeps the dynamic cells alive. The block resolves these agents with a fixed priority and registers the resulting per-row read and write enables, so the memory sees them one cycle after the request.

Refresh is opportunistic. A small counter names the row that is due for refresh. In an idle cycle that row is read and written back. If the row being read for a switch or a programming read matches the counter, it is rewritten in the same cycle, because a read in the first half of the cycle can be written back in the second half. The counter advances only when a refresh actually takes place.

A programming read that arrives with a switch to a different context cannot be served, because both would use the shared column bus. The block does not arbitrate this case. It raises a conflict flag.

Top module: `ctxmem_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rd_en_o` and `wr_en_o` are all zero, `drv_sel_o` is 2'b00 and `conflict_o` is 0. The refresh counter restarts at context 0.
- R2: Every output is registered. A request presented in one cycle changes the outputs only after the next rising clock edge.
- R3: When `switch_i` is high, `rd_en_o` has exactly the bit of `op_ctx_i` set, and `drv_sel_o` is 2'b01, which means the row drives the logic. This holds even when a programming read is also requested.
- R4: When `prog_rd_i` is high and `switch_i` is low, `rd_en_o` has the bit of `prog_ctx_i` set, and `drv_sel_o` is 2'b10, which means the row drives the programming lines.
- R5: When `prog_wr_i` is high, `wr_en_o` has exactly the bit of `prog_ctx_i` set. This holds whether or not a switch happens in the same cycle.
- R6: In a cycle with no switch, no programming read and no programming write, the row named by the refresh counter gets both its read and its write enable, and `drv_sel_o` is 2'b00.
- R7: The refresh counter advances by one, wrapping from 3 to 0, in exactly the cycles in which a refresh write happens. It holds its value in every other cycle.
- R8: During a switch with no programming write and no conflict, if `op_ctx_i` equals the refresh counter, that row also gets its write enable and the counter advances.
- R9: When `switch_i` and `prog_rd_i` are both high and `prog_ctx_i` differs from `op_ctx_i`, `conflict_o` is 1 in the next cycle. No refresh write happens and the counter holds.
- R10: During a programming read without a switch and with no programming write, if `prog_ctx_i` equals the refresh counter, that row also gets its write enable and the counter advances.
- R11: A switch and a programming read to the same context is legal. `conflict_o` stays 0 and `drv_sel_o` is 2'b01.
- R12: At most one bit of `rd_en_o` and at most one bit of `wr_en_o` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| op_ctx_i | input | 2 | Target context of an operating switch |
| switch_i | input | 1 | Operating-context switch request |
| prog_ctx_i | input | 2 | Context addressed by programming |
| prog_rd_i | input | 1 | Programming read request |
| prog_wr_i | input | 1 | Programming write request |
| rd_en_o | output | 4 | Registered per-context read enables |
| wr_en_o | output | 4 | Registered per-context write enables |
| drv_sel_o | output | 2 | Output drive select: 00 none, 01 logic, 10 programming lines |
| conflict_o | output | 1 | Illegal switch and programming-read combination seen last cycle |

## Verification
Every result of this block is due exactly one rising edge after its request. The bench drives each request just after an edge and checks that the outputs still hold the previous vector before the next edge. It then samples one time unit after that edge, against a refresh-counter model kept in the bench. The refresh counter can only be seen through the row that an idle cycle enables. The bench therefore tracks the counter and uses idle cycles to confirm both that it advanced and that it held.

// File: rtl/ctxmem_pkg.sv
package ctxmem_pkg;

  typedef enum logic [1:0] {
    DRV_NONE  = 2'b00,
    DRV_LOGIC = 2'b01,
    DRV_PROG  = 2'b10
  } drv_e;

endpackage

// File: rtl/ctxmem_refresh_ctr.sv
module ctxmem_refresh_ctr #(
  parameter int NUM_CTX = 4,
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [CTX_W-1:0] cnt_o
);

  logic [CTX_W-1:0] cnt_q, cnt_d, cnt_inc;

  generate
    if ((1 << CTX_W) == NUM_CTX) begin : g_pow2
      assign cnt_inc = cnt_q + CTX_W'(1);
    end else begin : g_wrap
      assign cnt_inc = (cnt_q == CTX_W'(NUM_CTX - 1)) ? '0 : cnt_q + CTX_W'(1);
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (adv_i) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R7
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(cnt_q));

endmodule

// File: rtl/ctxmem_arbiter.sv
module ctxmem_arbiter
  import ctxmem_pkg::*;
#(
  parameter int NUM_CTX = 4,
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [CTX_W-1:0] op_ctx_i,
  input  logic             switch_i,
  input  logic [CTX_W-1:0] prog_ctx_i,
  input  logic             prog_rd_i,
  input  logic             prog_wr_i,
  input  logic [CTX_W-1:0] ref_ctx_i,
  output logic             rd_act_o,
  output logic [CTX_W-1:0] rd_row_o,
  output logic             wr_act_o,
  output logic [CTX_W-1:0] wr_row_o,
  output logic             refresh_o,
  output drv_e             drv_o,
  output logic             conflict_o
);

  logic ref_match;

  always_comb begin
    conflict_o = switch_i && prog_rd_i && (prog_ctx_i != op_ctx_i);

    if (switch_i) begin
      rd_act_o = 1'b1;
      rd_row_o = op_ctx_i;
      drv_o    = DRV_LOGIC;
    end else if (prog_rd_i) begin
      rd_act_o = 1'b1;
      rd_row_o = prog_ctx_i;
      drv_o    = DRV_PROG;
    end else if (!prog_wr_i) begin
      rd_act_o = 1'b1;
      rd_row_o = ref_ctx_i;
      drv_o    = DRV_NONE;
    end else begin
      rd_act_o = 1'b0;
      rd_row_o = '0;
      drv_o    = DRV_NONE;
    end

    ref_match = (rd_row_o == ref_ctx_i);
    refresh_o = rd_act_o && ref_match && !prog_wr_i && !conflict_o;

    if (prog_wr_i) begin
      wr_act_o = 1'b1;
      wr_row_o = prog_ctx_i;
    end else if (refresh_o) begin
      wr_act_o = 1'b1;
      wr_row_o = ref_ctx_i;
    end else begin
      wr_act_o = 1'b0;
      wr_row_o = '0;
    end
  end

endmodule

// File: rtl/ctxmem_enable_pipe.sv
module ctxmem_enable_pipe
  import ctxmem_pkg::*;
#(
  parameter int NUM_CTX = 4,
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_act_i,
  input  logic [CTX_W-1:0]   rd_row_i,
  input  logic               wr_act_i,
  input  logic [CTX_W-1:0]   wr_row_i,
  input  drv_e               drv_i,
  input  logic               conflict_i,
  output logic [NUM_CTX-1:0] rd_en_o,
  output logic [NUM_CTX-1:0] wr_en_o,
  output drv_e               drv_o,
  output logic               conflict_o
);

  logic [NUM_CTX-1:0] rd_en_d, wr_en_d, rd_en_q, wr_en_q;
  drv_e               drv_q;
  logic               conflict_q;

  generate
    for (genvar k = 0; k < NUM_CTX; k++) begin : g_row
      assign rd_en_d[k] = rd_act_i && (rd_row_i == CTX_W'(k));
      assign wr_en_d[k] = wr_act_i && (wr_row_i == CTX_W'(k));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q    <= '0;
      wr_en_q    <= '0;
      drv_q      <= DRV_NONE;
      conflict_q <= 1'b0;
    end else begin
      rd_en_q    <= rd_en_d;
      wr_en_q    <= wr_en_d;
      drv_q      <= drv_i;
      conflict_q <= conflict_i;
    end
  end

  assign rd_en_o    = rd_en_q;
  assign wr_en_o    = wr_en_q;
  assign drv_o      = drv_q;
  assign conflict_o = conflict_q;

  // R12
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en_q));
  // R12
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_en_q) <= 1);
  // R3
  drv_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_q != DRV_NONE) |-> $onehot(rd_en_q));
  // R9
  conflict_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_q |-> (drv_q == DRV_LOGIC));

endmodule

// File: rtl/ctxmem_ctrl.sv
module ctxmem_ctrl
  import ctxmem_pkg::*;
#(
  parameter int NUM_CTX = 4,
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CTX_W-1:0]   op_ctx_i,
  input  logic               switch_i,
  input  logic [CTX_W-1:0]   prog_ctx_i,
  input  logic               prog_rd_i,
  input  logic               prog_wr_i,
  output logic [NUM_CTX-1:0] rd_en_o,
  output logic [NUM_CTX-1:0] wr_en_o,
  output logic [1:0]         drv_sel_o,
  output logic               conflict_o
);

  logic [CTX_W-1:0] ref_ctx, rd_row, wr_row;
  logic             rd_act, wr_act, refresh, conflict;
  drv_e             drv_d, drv_q;

  ctxmem_refresh_ctr #(.NUM_CTX(NUM_CTX)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (refresh),
    .cnt_o (ref_ctx)
  );

  ctxmem_arbiter #(.NUM_CTX(NUM_CTX)) arb_i (
    .op_ctx_i   (op_ctx_i),
    .switch_i   (switch_i),
    .prog_ctx_i (prog_ctx_i),
    .prog_rd_i  (prog_rd_i),
    .prog_wr_i  (prog_wr_i),
    .ref_ctx_i  (ref_ctx),
    .rd_act_o   (rd_act),
    .rd_row_o   (rd_row),
    .wr_act_o   (wr_act),
    .wr_row_o   (wr_row),
    .refresh_o  (refresh),
    .drv_o      (drv_d),
    .conflict_o (conflict)
  );

  ctxmem_enable_pipe #(.NUM_CTX(NUM_CTX)) pipe_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_act_i   (rd_act),
    .rd_row_i   (rd_row),
    .wr_act_i   (wr_act),
    .wr_row_i   (wr_row),
    .drv_i      (drv_d),
    .conflict_i (conflict),
    .rd_en_o    (rd_en_o),
    .wr_en_o    (wr_en_o),
    .drv_o      (drv_q),
    .conflict_o (conflict_o)
  );

  assign drv_sel_o = drv_q;

  // R9
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> conflict_o && $stable(ref_ctx));
  // R5
  prog_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_wr_i |=> $onehot(wr_en_o));
  // R6
  idle_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!switch_i && !prog_rd_i && !prog_wr_i) |=> (rd_en_o == wr_en_o) && $onehot(rd_en_o));

endmodule

// File: tb/ctxmem_ctrl_tb_top.sv
`timescale 1ns/1ps
module ctxmem_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_ctx, prog_ctx;
  logic       sw, prd, pwr;
  logic [3:0] rd_en, wr_en;
  logic [1:0] drv;
  logic       conf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int ref_m = 0;
  logic [3:0] prev_rd = '0, prev_wr = '0;
  logic [1:0] prev_drv = '0;

  always #2 clk = ~clk;

  ctxmem_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_ctx_i(op_ctx), .switch_i(sw),
    .prog_ctx_i(prog_ctx), .prog_rd_i(prd), .prog_wr_i(pwr),
    .rd_en_o(rd_en), .wr_en_o(wr_en), .drv_sel_o(drv), .conflict_o(conf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic r, input logic w,
                       input logic [1:0] oc, input logic [1:0] pc);
    logic cf, ract, refr;
    logic [1:0] row;
    logic [3:0] erd, ewr;
    logic [1:0] edrv;
    string tag;
    sw = s; prd = r; pwr = w; op_ctx = oc; prog_ctx = pc;
    cf   = s && r && (oc != pc);
    ract = s || r || !w;
    row  = s ? oc : (r ? pc : 2'(ref_m));
    refr = ract && (row == 2'(ref_m)) && !w && !cf;
    erd  = ract ? (4'b1 << row) : 4'b0;
    ewr  = w ? (4'b1 << pc) : (refr ? (4'b1 << ref_m) : 4'b0);
    edrv = s ? 2'b01 : (r ? 2'b10 : 2'b00);
    if (cf) tag = "R9";
    else if (s && r) tag = "R11";
    else if (refr && s) tag = "R8";
    else if (refr && r) tag = "R10";
    else if (refr) tag = "R6";
    else if (s) tag = "R3";
    else if (r) tag = "R4";
    else tag = "R5";
    #1;
    chk("R2 rd_en held", 32'(rd_en), 32'(prev_rd));
    chk("R2 wr_en held", 32'(wr_en), 32'(prev_wr));
    @(posedge clk); #1;
    chk({tag, " rd_en"}, 32'(rd_en), 32'(erd));
    chk(w ? "R5 wr_en" : {tag, " wr_en"}, 32'(wr_en), 32'(ewr));
    chk({tag, " drv_sel"}, 32'(drv), 32'(edrv));
    chk({tag, " conflict"}, 32'(conf), 32'(cf));
    chk("R12 onehot", 32'($countones(rd_en) <= 1 && $countones(wr_en) <= 1), 32'd1);
    if (refr) ref_m = (ref_m + 1) % 4;
    prev_rd = erd; prev_wr = ewr; prev_drv = edrv;
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw = 0; prd = 0; pwr = 0; op_ctx = 0; prog_ctx = 0;
    #1;
    chk("R1 rd_en in reset", 32'(rd_en), 32'd0);
    chk("R1 wr_en in reset", 32'(wr_en), 32'd0);
    chk("R1 drv_sel in reset", 32'(drv), 32'd0);
    chk("R1 conflict in reset", 32'(conf), 32'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: first idle cycle refreshes context 0; R7 wrap over several idles
    for (int i = 0; i < 6; i++) apply(0, 0, 0, 0, 0);
    // R7: write-only cycles hold the counter; next idle shows same row
    for (int i = 0; i < 3; i++) apply(0, 0, 1, 2'(i), 2'(i));
    apply(0, 0, 0, 0, 0);
    // exhaustive sweep of request combinations, three passes
    for (int p = 0; p < 3; p++)
      for (int c = 0; c < 128; c++)
        apply(c[6], c[5], c[4], c[3:2], c[1:0]);
    // R9: conflict holds the counter, seen via the following idle
    apply(1, 1, 0, 1, 3);
    apply(0, 0, 0, 0, 0);
    // R1: mid-run reset restarts counter at 0
    apply(0, 0, 0, 0, 0);
    rst_n = 1'b0; #1;
    chk("R1 rd_en after reset", 32'(rd_en), 32'd0);
    chk("R1 conflict after reset", 32'(conf), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    ref_m = 0; prev_rd = '0; prev_wr = '0; prev_drv = '0;
    apply(0, 0, 0, 0, 0);
    chk("R1 counter restarts at 0", 32'(rd_en), 32'd1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule